// File: doc/BRIEF.md
# Issue-Group Dependence Cross-Checker

This block is the stall decision at the decode stage of an in-order pipeline that issues up to `WIDTH` instructions per cycle (`WIDTH` from 2 to 4). Each cycle the decoder presents a group of slots in program order, with slot 0 the oldest. Each slot carries two source register indices, a destination index with a write-enable, and flags for load, store and divide. The block returns how many leading slots may issue together this cycle. The remaining slots are held, and the front end presents them again the next cycle as the oldest slots of the new group.

A slot ends the group when any of these apply:
- it is not valid;
- it reads a register written by an older slot of the same group, found by a triangular cross-check of every younger source against every older destination;
- it reads the destination of a load issued in the previous active cycle;
- it would exceed the number of memory ports (loads and stores together);
- it would exceed the number of divide units.

The block keeps its own record of the loads it let issue, so the load-to-use check needs no extra inputs. A global hold input freezes issue and keeps that record unchanged.

Top module: `issue_xcheck`

## Requirements
- R1: Once reset is released the load record is empty, so a group of `WIDTH` valid, mutually independent, non-memory, non-divide slots issues in full.
- R2: A slot is blocked if either of its sources equals the destination of an older valid slot in the same group that has write-enable set and a nonzero destination. The count then equals the index of the first such slot.
- R3: The second source field is compared exactly like the first one.
- R4: Register index 0 never creates a dependence. An older slot with write-enable clear creates none either. A load whose destination is 0 or whose write-enable is clear leaves nothing in the load record.
- R5: A slot that reads the destination of a load issued in the previous active cycle is blocked. The load may have been in any issued slot. Slot 0 is blocked the same way, which gives a count of 0.
- R6: The load record covers one active cycle only. On each non-held clock edge it is replaced by the loads issued in that cycle, and it becomes empty when nothing issued.
- R7: With one memory port (default), a load or store is blocked if an older valid slot in the group is also a load or store.
- R8: With one divide unit (default), a divide is blocked if an older valid slot in the group is also a divide.
- R9: The first invalid slot ends the group. An all-invalid group gives a count of 0, and the count never exceeds `WIDTH`.
- R10: While `hold_all` is high the count is 0. The load record is kept across held edges and applies again once the hold is released.
- R11: When `hold_all` is low and slot 0 is valid and free of a load-to-use hazard, the count is at least 1.
- R12: The count equals the index of the first slot that meets any blocking condition, or `WIDTH` if no slot does. No slot after a blocked one issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_all | input | 1 | External stall: nothing issues and the load record is kept |
| grp_valid | input | WIDTH | Slot k present (bit k = slot k, slot 0 oldest) |
| grp_src_a | input | WIDTH x REG_W | First source register of each slot |
| grp_src_b | input | WIDTH x REG_W | Second source register of each slot |
| grp_dst | input | WIDTH x REG_W | Destination register of each slot |
| grp_wen | input | WIDTH | Slot writes its destination |
| grp_load | input | WIDTH | Slot is a load (uses a memory port) |
| grp_store | input | WIDTH | Slot is a store (uses a memory port) |
| grp_div | input | WIDTH | Slot uses the divide unit |
| issue_cnt | output | clog2(WIDTH+1) | Number of leading slots issuing this cycle, unsigned binary |

## Verification
The issue count is combinational, so it is due in the same cycle the group is presented. The bench drives each group on the falling edge and reads the count 3 ns later, before the next rising edge. A load takes effect on the rising edge that follows its issue, so the next group, driven after that edge, must show the stall. That group must stay unblocked one further active cycle later, and stay unblocked across any number of held edges in between. The bench updates its own model of the load record only after that same edge, using the count it predicted. A sweep over a small configuration with eight registers makes collisions frequent. The sweep compares every cycle with an arithmetic model of the requirements.

// File: rtl/issue_xcheck_pkg.sv
package issue_xcheck_pkg;

  // Why a slot stops the issue group; NONE means the slot may issue.
  typedef enum logic [2:0] {
    STOP_NONE,
    STOP_HOLD,
    STOP_EMPTY,
    STOP_LDUSE,
    STOP_RAW,
    STOP_MEMPORT,
    STOP_DIVUNIT
  } stop_cause_e;

endpackage

// File: rtl/xchk_rst_sync.sv
module xchk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/xchk_raw_matrix.sv
// Triangular cross-check of younger sources against older destinations.
// Younger port index k holds slot k+1; older port index k holds slot k.
module xchk_raw_matrix #(
  parameter int WIDTH = 4,
  parameter int REG_W = 5
) (
  input  logic [WIDTH-2:0]            old_valid,
  input  logic [WIDTH-2:0]            old_wen,
  input  logic [WIDTH-2:0][REG_W-1:0] old_dst,
  input  logic [WIDTH-2:0]            yng_valid,
  input  logic [WIDTH-2:0][REG_W-1:0] yng_src_a,
  input  logic [WIDTH-2:0][REG_W-1:0] yng_src_b,
  output logic [WIDTH-1:0]            raw_hit
);

  logic [WIDTH-2:0] writer;

  // An older slot only matters if it is present and writes a real register.
  for (genvar gw = 0; gw < WIDTH-1; gw++) begin : g_writer
    assign writer[gw] = old_valid[gw] & old_wen[gw] & (old_dst[gw] != '0);
  end

  // Slot 0 has no older slot in its group.
  assign raw_hit[0] = 1'b0;

  for (genvar gj = 1; gj < WIDTH; gj++) begin : g_younger
    logic [gj-1:0] pair_hit;
    for (genvar gi = 0; gi < gj; gi++) begin : g_older
      assign pair_hit[gi] = writer[gi] & yng_valid[gj-1] &
                            ((old_dst[gi] == yng_src_a[gj-1]) |
                             (old_dst[gi] == yng_src_b[gj-1]));
    end
    assign raw_hit[gj] = |pair_hit;
  end

endmodule

// File: rtl/xchk_struct.sv
// Flags each slot that would need more units of one kind than LIMIT.
module xchk_struct #(
  parameter int WIDTH = 4,
  parameter int LIMIT = 1
) (
  input  logic [WIDTH-1:0] valid,
  input  logic [WIDTH-1:0] use_unit,
  output logic [WIDTH-1:0] over
);

  logic [WIDTH-1:0] claim;

  assign claim = valid & use_unit;

  if (LIMIT == 1) begin : g_single
    // One unit: any older claim blocks, a plain prefix OR.
    logic [WIDTH-1:0] older_any;
    assign older_any[0] = 1'b0;
    for (genvar gj = 1; gj < WIDTH; gj++) begin : g_pref
      assign older_any[gj] = older_any[gj-1] | claim[gj-1];
    end
    assign over = use_unit & older_any;
  end else begin : g_multi
    // Several units: running count of older claims.
    always_comb begin
      int seen;
      seen = 0;
      for (int j = 0; j < WIDTH; j++) begin
        over[j] = use_unit[j] && (seen >= LIMIT);
        if (claim[j]) seen = seen + 1;
      end
    end
  end

endmodule

// File: rtl/xchk_lduse.sv
// Keeps the destinations of loads issued last active cycle and flags readers.
module xchk_lduse #(
  parameter int WIDTH = 4,
  parameter int REG_W = 5,
  parameter int CNT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold_all,
  input  logic [CNT_W-1:0]           issue_cnt,
  input  logic [WIDTH-1:0]           valid,
  input  logic [WIDTH-1:0]           wen,
  input  logic [WIDTH-1:0]           load,
  input  logic [WIDTH-1:0][REG_W-1:0] dst,
  input  logic [WIDTH-1:0][REG_W-1:0] src_a,
  input  logic [WIDTH-1:0][REG_W-1:0] src_b,
  output logic [WIDTH-1:0]           lduse_hit
);

  logic [WIDTH-1:0]            live_q;
  logic [WIDTH-1:0]            live_d;
  logic [WIDTH-1:0][REG_W-1:0] rdst_q;
  logic [WIDTH-1:0][REG_W-1:0] rdst_d;
  logic                        rec_en;

  // Frozen pipeline keeps the load in execute, so the record holds.
  assign rec_en = ~hold_all;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      live_d[i] = (i < int'(issue_cnt)) && valid[i] && load[i] &&
                  wen[i] && (dst[i] != '0);
      rdst_d[i] = dst[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (rec_en) begin
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rec_en) begin
      rdst_q <= rdst_d;
    end
  end

  for (genvar gj = 0; gj < WIDTH; gj++) begin : g_reader
    logic [WIDTH-1:0] hit_vec;
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_rec
      assign hit_vec[gi] = live_q[gi] &
                           ((rdst_q[gi] == src_a[gj]) |
                            (rdst_q[gi] == src_b[gj]));
    end
    assign lduse_hit[gj] = |hit_vec;
  end

endmodule

// File: rtl/issue_xcheck.sv
module issue_xcheck
  import issue_xcheck_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int REG_W     = 5,
  parameter int MEM_PORTS = 1,
  parameter int DIV_UNITS = 1,
  localparam int CNT_W    = $clog2(WIDTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold_all,
  input  logic [WIDTH-1:0]            grp_valid,
  input  logic [WIDTH-1:0][REG_W-1:0] grp_src_a,
  input  logic [WIDTH-1:0][REG_W-1:0] grp_src_b,
  input  logic [WIDTH-1:0][REG_W-1:0] grp_dst,
  input  logic [WIDTH-1:0]            grp_wen,
  input  logic [WIDTH-1:0]            grp_load,
  input  logic [WIDTH-1:0]            grp_store,
  input  logic [WIDTH-1:0]            grp_div,
  output logic [CNT_W-1:0]            issue_cnt
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] raw_hit;
  logic [WIDTH-1:0] lduse_hit;
  logic [WIDTH-1:0] mem_over;
  logic [WIDTH-1:0] div_over;
  logic [WIDTH-1:0] mem_use;
  logic [CNT_W-1:0] cnt_d;
  stop_cause_e      slot_cause [WIDTH];

  assign mem_use = grp_load | grp_store;

  xchk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xchk_raw_matrix #(
    .WIDTH (WIDTH),
    .REG_W (REG_W)
  ) u_raw (
    .old_valid (grp_valid[WIDTH-2:0]),
    .old_wen   (grp_wen[WIDTH-2:0]),
    .old_dst   (grp_dst[WIDTH-2:0]),
    .yng_valid (grp_valid[WIDTH-1:1]),
    .yng_src_a (grp_src_a[WIDTH-1:1]),
    .yng_src_b (grp_src_b[WIDTH-1:1]),
    .raw_hit   (raw_hit)
  );

  xchk_lduse #(
    .WIDTH (WIDTH),
    .REG_W (REG_W),
    .CNT_W (CNT_W)
  ) u_lduse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hold_all  (hold_all),
    .issue_cnt (cnt_d),
    .valid     (grp_valid),
    .wen       (grp_wen),
    .load      (grp_load),
    .dst       (grp_dst),
    .src_a     (grp_src_a),
    .src_b     (grp_src_b),
    .lduse_hit (lduse_hit)
  );

  xchk_struct #(
    .WIDTH (WIDTH),
    .LIMIT (MEM_PORTS)
  ) u_mem (
    .valid    (grp_valid),
    .use_unit (mem_use),
    .over     (mem_over)
  );

  xchk_struct #(
    .WIDTH (WIDTH),
    .LIMIT (DIV_UNITS)
  ) u_div (
    .valid    (grp_valid),
    .use_unit (grp_div),
    .over     (div_over)
  );

  // Per-slot verdict; any reason other than NONE stops the group there.
  always_comb begin
    for (int j = 0; j < WIDTH; j++) begin
      if (hold_all)          slot_cause[j] = STOP_HOLD;
      else if (!grp_valid[j]) slot_cause[j] = STOP_EMPTY;
      else if (lduse_hit[j]) slot_cause[j] = STOP_LDUSE;
      else if (raw_hit[j])   slot_cause[j] = STOP_RAW;
      else if (mem_over[j])  slot_cause[j] = STOP_MEMPORT;
      else if (div_over[j])  slot_cause[j] = STOP_DIVUNIT;
      else                   slot_cause[j] = STOP_NONE;
    end
  end

  // In-order: the count runs up to the first stopping slot.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    cnt_d   = '0;
    for (int j = 0; j < WIDTH; j++) begin
      if (!blocked) begin
        if (slot_cause[j] == STOP_NONE) cnt_d = CNT_W'(j + 1);
        else                            blocked = 1'b1;
      end
    end
  end

  assign issue_cnt = cnt_d;

endmodule

// File: rtl/issue_xcheck_chk.sv
module issue_xcheck_chk #(
  parameter int WIDTH     = 4,
  parameter int REG_W     = 5,
  parameter int MEM_PORTS = 1,
  parameter int DIV_UNITS = 1,
  parameter int CNT_W     = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        hold_all,
  input logic [WIDTH-1:0]            grp_valid,
  input logic [WIDTH-1:0][REG_W-1:0] grp_src_a,
  input logic [WIDTH-1:0][REG_W-1:0] grp_src_b,
  input logic [WIDTH-1:0][REG_W-1:0] grp_dst,
  input logic [WIDTH-1:0]            grp_wen,
  input logic [WIDTH-1:0]            grp_load,
  input logic [WIDTH-1:0]            grp_store,
  input logic [WIDTH-1:0]            grp_div,
  input logic [CNT_W-1:0]            issue_cnt
);

  // Checker-side record of loads seen issuing at the ports.
  logic [WIDTH-1:0]            seen_live_q;
  logic [WIDTH-1:0][REG_W-1:0] seen_dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_live_q <= '0;
      seen_dst_q  <= '0;
    end else if (!hold_all) begin
      for (int i = 0; i < WIDTH; i++) begin
        seen_live_q[i] <= (i < int'(issue_cnt)) && grp_valid[i] && grp_load[i] &&
                          grp_wen[i] && (grp_dst[i] != '0);
        seen_dst_q[i]  <= grp_dst[i];
      end
    end
  end

  int   n_mem;
  int   n_div;
  logic bad_valid;
  logic bad_raw;
  logic bad_lduse;
  logic slot0_free;

  always_comb begin
    n_mem     = 0;
    n_div     = 0;
    bad_valid = 1'b0;
    bad_raw   = 1'b0;
    bad_lduse = 1'b0;
    slot0_free = grp_valid[0];
    for (int k = 0; k < WIDTH; k++) begin
      if (seen_live_q[k] && ((seen_dst_q[k] == grp_src_a[0]) ||
                             (seen_dst_q[k] == grp_src_b[0])))
        slot0_free = 1'b0;
    end
    for (int j = 0; j < WIDTH; j++) begin
      if (j < int'(issue_cnt)) begin
        if (!grp_valid[j]) bad_valid = 1'b1;
        if (grp_load[j] || grp_store[j]) n_mem = n_mem + 1;
        if (grp_div[j]) n_div = n_div + 1;
        for (int i = 0; i < j; i++) begin
          if (grp_wen[i] && (grp_dst[i] != '0) &&
              ((grp_dst[i] == grp_src_a[j]) || (grp_dst[i] == grp_src_b[j])))
            bad_raw = 1'b1;
        end
        for (int k = 0; k < WIDTH; k++) begin
          if (seen_live_q[k] && ((seen_dst_q[k] == grp_src_a[j]) ||
                                 (seen_dst_q[k] == grp_src_b[j])))
            bad_lduse = 1'b1;
        end
      end
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_cnt) <= WIDTH);

  a_r9_only_valid_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_valid);

  a_r2_no_raw_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_raw);

  a_r5_no_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_lduse);

  a_r7_mem_port_limit: assert property (@(posedge clk) disable iff (!rst_n)
    n_mem <= MEM_PORTS);

  a_r8_div_unit_limit: assert property (@(posedge clk) disable iff (!rst_n)
    n_div <= DIV_UNITS);

  a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all |-> (issue_cnt == '0));

  a_r11_slot0_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_all && slot0_free) |-> (issue_cnt != '0));

endmodule

bind issue_xcheck issue_xcheck_chk #(
  .WIDTH     (WIDTH),
  .REG_W     (REG_W),
  .MEM_PORTS (MEM_PORTS),
  .DIV_UNITS (DIV_UNITS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hold_all  (hold_all),
  .grp_valid (grp_valid),
  .grp_src_a (grp_src_a),
  .grp_src_b (grp_src_b),
  .grp_dst   (grp_dst),
  .grp_wen   (grp_wen),
  .grp_load  (grp_load),
  .grp_store (grp_store),
  .grp_div   (grp_div),
  .issue_cnt (issue_cnt)
);

// File: tb/tb_issue_xcheck.sv
module tb_issue_xcheck;

  localparam int W  = 4;
  localparam int RB = 3;
  localparam int CW = $clog2(W + 1);

  logic              clk;
  logic              rst_n;
  logic              hold;
  logic [W-1:0]      v, we, ld, st, dv;
  logic [W-1:0][RB-1:0] sa, sb, d;
  logic [CW-1:0]     issue_cnt;

  logic [(1<<RB)-1:0] ld_set;   // bench model of last-cycle load destinations
  int checks;
  int failures;
  logic [31:0] rng;

  issue_xcheck #(.WIDTH(W), .REG_W(RB), .MEM_PORTS(1), .DIV_UNITS(1)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_all  (hold),
    .grp_valid (v),
    .grp_src_a (sa),
    .grp_src_b (sb),
    .grp_dst   (d),
    .grp_wen   (we),
    .grp_load  (ld),
    .grp_store (st),
    .grp_div   (dv),
    .issue_cnt (issue_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: issue count got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_grp();
    v = '0; we = '0; ld = '0; st = '0; dv = '0;
    sa = '0; sb = '0; d = '0; hold = 1'b0;
  endtask

  task automatic set_slot(input int j, input int a, input int b, input int dd, input bit w);
    v[j] = 1'b1; sa[j] = RB'(a); sb[j] = RB'(b); d[j] = RB'(dd); we[j] = w;
  endtask

  task automatic update_model(input int exp);
    if (!hold) begin
      ld_set = '0;
      for (int i = 0; i < exp; i++)
        if (v[i] && ld[i] && we[i] && d[i] != '0) ld_set[d[i]] = 1'b1;
    end
  endtask

  // Called right after a falling edge with inputs already set.
  task automatic step(input string req, input int exp);
    #3;
    check(req, int'(issue_cnt), exp);
    @(posedge clk);
    update_model(exp);
    @(negedge clk);
  endtask

  task automatic flush();
    clear_grp();
    step("R9", 0);
  endtask

  function automatic int model_cnt();
    int n_mem;
    int n_div;
    n_mem = 0;
    n_div = 0;
    if (hold) return 0;
    for (int j = 0; j < W; j++) begin
      if (!v[j]) return j;
      if (ld_set[sa[j]] || ld_set[sb[j]]) return j;
      for (int i = 0; i < j; i++)
        if (we[i] && d[i] != '0 && (d[i] == sa[j] || d[i] == sb[j])) return j;
      if (ld[j] || st[j]) begin
        if (n_mem >= 1) return j;
        n_mem++;
      end
      if (dv[j]) begin
        if (n_div >= 1) return j;
        n_div++;
      end
    end
    return W;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    ld_set = '0;
    rng = 32'h1234_abcd;
    rst_n = 1'b0;
    clear_grp();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: nothing stale after reset
    clear_grp();
    set_slot(0, 1, 2, 3, 1); set_slot(1, 4, 5, 6, 1);
    set_slot(2, 7, 7, 1, 1); set_slot(3, 0, 0, 0, 0);
    step("R1", 4);

    // R2: slot 2 reads slot 0's destination
    clear_grp();
    set_slot(0, 1, 2, 3, 1); set_slot(1, 4, 5, 6, 1);
    set_slot(2, 3, 7, 1, 1); set_slot(3, 2, 2, 4, 1);
    step("R2", 2);

    // R3: second source field
    clear_grp();
    set_slot(0, 1, 2, 5, 1); set_slot(1, 4, 5, 6, 1);
    step("R3", 1);

    // R4: register 0 and write-enable clear
    clear_grp();
    set_slot(0, 1, 2, 0, 1); set_slot(1, 0, 0, 6, 1);
    set_slot(2, 0, 3, 7, 1); set_slot(3, 4, 4, 2, 1);
    step("R4", 4);
    clear_grp();
    set_slot(0, 1, 2, 5, 0); set_slot(1, 5, 5, 6, 1);
    set_slot(2, 3, 3, 7, 1); set_slot(3, 1, 1, 2, 1);
    step("R4", 4);

    // R5 / R6: load in slot 0, consumer in slot 1
    flush();
    clear_grp();
    set_slot(0, 1, 2, 5, 1); ld[0] = 1'b1; set_slot(1, 3, 4, 6, 1);
    set_slot(2, 1, 3, 7, 1); set_slot(3, 2, 2, 1, 1);
    step("R5", 4);
    clear_grp();
    set_slot(0, 1, 2, 3, 1); set_slot(1, 5, 1, 6, 1);
    step("R5", 1);
    step("R6", 2);

    // R5 / R6: load in slot 2, consumer in slot 0
    clear_grp();
    set_slot(0, 1, 2, 3, 1); set_slot(1, 4, 4, 5, 1);
    set_slot(2, 1, 1, 6, 1); ld[2] = 1'b1; set_slot(3, 2, 2, 7, 1);
    step("R5", 4);
    clear_grp();
    set_slot(0, 6, 1, 2, 1); set_slot(1, 1, 1, 3, 1);
    step("R5", 0);
    step("R6", 2);

    // R4: load to register 0 leaves no record
    clear_grp();
    set_slot(0, 1, 2, 0, 1); ld[0] = 1'b1; set_slot(1, 3, 3, 4, 1);
    step("R4", 2);
    clear_grp();
    set_slot(0, 0, 0, 5, 1); set_slot(1, 0, 1, 6, 1);
    step("R4", 2);

    // R10: hold blocks and keeps the record
    flush();
    clear_grp();
    set_slot(0, 1, 1, 7, 1); ld[0] = 1'b1; set_slot(1, 2, 2, 3, 1);
    step("R10", 2);
    clear_grp();
    set_slot(0, 1, 1, 4, 1); set_slot(1, 7, 7, 5, 1); hold = 1'b1;
    step("R10", 0);
    step("R10", 0);
    hold = 1'b0;
    step("R10", 1);

    // R7: one memory port
    flush();
    clear_grp();
    set_slot(0, 1, 2, 0, 0); st[0] = 1'b1; set_slot(1, 3, 3, 4, 1);
    set_slot(2, 1, 1, 5, 1); ld[2] = 1'b1; set_slot(3, 2, 2, 6, 1);
    step("R7", 2);
    flush();
    clear_grp();
    set_slot(0, 1, 1, 2, 1); set_slot(1, 3, 3, 4, 1); ld[1] = 1'b1;
    set_slot(2, 1, 1, 5, 1); ld[2] = 1'b1; set_slot(3, 1, 1, 6, 1);
    step("R7", 2);
    flush();
    clear_grp();
    set_slot(0, 1, 1, 2, 1); ld[0] = 1'b1; set_slot(1, 3, 3, 4, 1);
    set_slot(2, 5, 5, 6, 1); set_slot(3, 1, 1, 0, 0); st[3] = 1'b1;
    step("R7", 3);

    // R8: one divide unit
    flush();
    clear_grp();
    set_slot(0, 1, 1, 2, 1); set_slot(1, 3, 3, 4, 1); dv[1] = 1'b1;
    set_slot(2, 5, 5, 6, 1); set_slot(3, 1, 1, 7, 1); dv[3] = 1'b1;
    step("R8", 3);
    clear_grp();
    set_slot(0, 1, 1, 2, 1); dv[0] = 1'b1; set_slot(1, 3, 3, 4, 1); dv[1] = 1'b1;
    step("R8", 1);

    // R9: hole in the group
    clear_grp();
    set_slot(0, 1, 1, 2, 1); set_slot(2, 3, 3, 4, 1); set_slot(3, 5, 5, 6, 1);
    step("R9", 1);

    // R11: slot 0 issues even when everything after it is blocked
    clear_grp();
    set_slot(0, 1, 1, 2, 1); st[0] = 1'b1; dv[0] = 1'b1;
    set_slot(1, 2, 2, 3, 1); st[1] = 1'b1;
    step("R11", 1);

    // R12 / R11: sweep with many register collisions
    flush();
    for (int n = 0; n < 3000; n++) begin
      int exp;
      int got;
      bit free0;
      clear_grp();
      for (int j = 0; j < W; j++) begin
        rng = next_rng(rng);
        v[j]  = (rng[2:0] != 3'd0);
        sa[j] = rng[5:3];
        sb[j] = rng[8:6];
        d[j]  = rng[11:9];
        we[j] = rng[12] | rng[13];
        ld[j] = (rng[15:14] == 2'd0);
        st[j] = (rng[18:16] == 3'd0);
        dv[j] = (rng[21:19] == 3'd0);
      end
      rng = next_rng(rng);
      hold = (rng[3:0] == 4'd0);
      exp = model_cnt();
      free0 = !hold && v[0] && !ld_set[sa[0]] && !ld_set[sb[0]];
      #3;
      got = int'(issue_cnt);
      check("R12", got, exp);
      if (free0) check("R11", (got >= 1) ? 1 : 0, 1);
      @(posedge clk);
      update_model(exp);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule